// File: doc/BRIEF.md
# Descriptor-Driven DMA Step Engine

This block carries out one transfer step of a DMA channel each time a dispatcher pulses its start input. With the start pulse the dispatcher presents the channel number and that channel's 8-byte descriptor. The descriptor holds a 24-bit buffer pointer, a control byte, a 16-bit pointer into the I/O page (addresses 0x000000 to 0x00FFFF) and a 16-bit remaining-byte counter. The engine reads the source and writes the destination over a 16-bit, two-lane byte-addressed memory bus with a ready handshake. It then hands back the updated descriptor together with a completion pulse. An end-of-block flag marks the step that empties the counter.

Word steps use one bus access on each side whose address is even. A side whose address is odd takes two byte accesses instead. A counter of zero stands for the largest block. A word step with one byte left shrinks to a byte step. When a channel allows it, a stop request raised with the start pulse aborts the block without touching the bus.

Top module: `dma_step_engine`

## Requirements
- R1: A byte step (control bit 3 = 0) makes exactly one read followed by one write, each one byte on the lane selected by address bit 0 (even address on byte enable bit 0 and data bits 7:0, odd address on byte enable bit 1 and data bits 15:8). The byte read is the byte written, and the counter drops by 1.
- R2: A word step (control bit 3 = 1, counter not 1) with both addresses even makes one two-lane read and one two-lane write. The byte at the lower address travels on bits 7:0. The counter drops by 2.
- R3: In a word step, a side with an odd address uses two byte accesses, first at its address and then at its address plus one. An even side still uses one word access. Byte order is preserved, so a step with one odd side takes 3 accesses and a step with both sides odd takes 4. The counter still drops by 2.
- R4: A word step whose counter is 1 is carried out as a byte step, and the counter becomes 0.
- R5: A counter of 0 means the maximum block. A byte step leaves 0xFFFF and a word step leaves 0xFFFE, and neither reports end of block.
- R6: Pointer updates after a step of N bytes: the I/O pointer stays put when control bit 4 = 1 and otherwise grows by N, wrapping within 16 bits. The buffer pointer stays put when control bit 2 = 1. Otherwise it moves by N, downward when control bit 5 = 1 and upward when it is 0. Every I/O-side access carries zero in address bits 23:16.
- R7: Control bit 1 = 0 moves data from the I/O address to the buffer address, and 1 moves it from the buffer to the I/O address.
- R8: When control bit 0 = 1 and the stop request is high with the start pulse, no bus access occurs. The next cycle shows completion, end and stop together, and the descriptor comes back unchanged. With control bit 0 = 0, the stop request has no effect.
- R9: End of block is reported, along with the channel number of the step, exactly when the returned counter is 0.
- R10: Busy rises in the cycle after an accepted start and falls as the final write completes. Completion is pulsed in that same cycle, with busy low. A start that arrives while busy is ignored.
- R11: While ready is low, the request, address, byte enables and direction of the pending access stay unchanged.
- R12: After reset, busy, request and completion are low.
- R13: The descriptor is packed as one 64-bit word: bits 23:0 buffer pointer, 31:24 control byte, 47:32 I/O pointer, 63:48 counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start one step (accepted only when not busy) |
| start_chan | input | CHAN_W | Channel number of the step |
| stop_req | input | 1 | Resource stop request, sampled with start |
| desc_in | input | 64 | Descriptor of the channel, valid with start |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle completion pulse |
| done_chan | output | CHAN_W | Channel of the completed step |
| blk_end | output | 1 | End of block, valid with done |
| blk_stop | output | 1 | Block aborted by stop request, valid with done |
| desc_wb | output | 64 | Updated descriptor, valid with done |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 24 | Byte address |
| mem_be | output | 2 | Byte lane enables |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| mem_ready | input | 1 | Access completes on a clock edge where request and ready are both high |

## Verification
The hardest cases to reach are those where the access pattern of each side is chosen separately from the parity of its own address. These include a split read followed by a word write, the reverse, and the case where both sides split, all combined with a counter that is at 1 or at 0. The stimulus sets these up directly by choosing descriptor addresses of each parity in both directions. It also feeds returned descriptors back in, so that a block runs down to its end across several steps. A pseudo-random ready pattern is active on part of the run, so that every access type is held in a wait state. One start is issued in the middle of a busy step to show that it is discarded.

// File: rtl/dma_step_pkg.sv
package dma_step_pkg;
  localparam int BAP_W  = 24;
  localparam int IOA_W  = 16;
  localparam int CNT_W  = 16;
  localparam int CTL_W  = 8;
  localparam int DESC_W = CNT_W + IOA_W + CTL_W + BAP_W;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;

  // control byte bit positions
  localparam int CB_BAP_DEC = 5;
  localparam int CB_IOA_FIX = 4;
  localparam int CB_WORD    = 3;
  localparam int CB_BAP_FIX = 2;
  localparam int CB_DIR     = 1;
  localparam int CB_STOP    = 0;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic [IOA_W-1:0] ioa;
    logic [CTL_W-1:0] ctl;
    logic [BAP_W-1:0] bap;
  } desc_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_A, ST_RD_B, ST_WR_A, ST_WR_B
  } step_st_t;

  typedef logic [1:0] nbytes_t;

  function automatic nbytes_t f_step_bytes(input logic word, input logic [CNT_W-1:0] cnt);
    return (word && cnt != CNT_W'(1)) ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [CNT_W-1:0] f_next_cnt(input logic [CNT_W-1:0] cnt, input nbytes_t nb);
    return cnt - CNT_W'(nb);
  endfunction

  function automatic logic [IOA_W-1:0] f_next_ioa(input logic [IOA_W-1:0] ioa, input logic fix,
                                                  input nbytes_t nb);
    return fix ? ioa : ioa + IOA_W'(nb);
  endfunction

  function automatic logic [BAP_W-1:0] f_next_bap(input logic [BAP_W-1:0] bap, input logic fix,
                                                  input logic dec, input nbytes_t nb);
    if (fix) return bap;
    if (dec) return bap - BAP_W'(nb);
    return bap + BAP_W'(nb);
  endfunction

  function automatic logic [BAP_W-1:0] f_io_addr(input logic [IOA_W-1:0] ioa);
    return {{(BAP_W-IOA_W){1'b0}}, ioa};
  endfunction

  function automatic logic [1:0] f_lane(input logic a0);
    return a0 ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [BYTE_W-1:0] f_pick_byte(input logic [DATA_W-1:0] d, input logic a0);
    return a0 ? d[DATA_W-1:BYTE_W] : d[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/dma_step_route.sv
module dma_step_route
  import dma_step_pkg::*;
(
  input  desc_t            desc,
  output logic [BAP_W-1:0] src_a,
  output logic [BAP_W-1:0] src_b,
  output logic [BAP_W-1:0] dst_a,
  output logic [BAP_W-1:0] dst_b,
  output nbytes_t          nbytes,
  output logic             rd_word,
  output logic             rd_split,
  output logic             wr_word,
  output logic             wr_split,
  output logic             src_is_io,
  output logic             dst_is_io
);
  logic [BAP_W-1:0] io_a, io_b, buf_a, buf_b;
  logic             to_io, two;

  always_comb begin
    io_a  = f_io_addr(desc.ioa);
    io_b  = f_io_addr(desc.ioa + IOA_W'(1));
    buf_a = desc.bap;
    buf_b = desc.bap + BAP_W'(1);
    to_io = desc.ctl[CB_DIR];
    src_a = to_io ? buf_a : io_a;
    src_b = to_io ? buf_b : io_b;
    dst_a = to_io ? io_a  : buf_a;
    dst_b = to_io ? io_b  : buf_b;
    src_is_io = !to_io;
    dst_is_io = to_io;
    nbytes   = f_step_bytes(desc.ctl[CB_WORD], desc.cnt);
    two      = (nbytes == 2'd2);
    rd_word  = two && !src_a[0];
    rd_split = two &&  src_a[0];
    wr_word  = two && !dst_a[0];
    wr_split = two &&  dst_a[0];
  end
endmodule

// File: rtl/dma_step_update.sv
module dma_step_update
  import dma_step_pkg::*;
(
  input  desc_t   cur,
  input  nbytes_t nbytes,
  output desc_t   nxt,
  output logic    zero_left
);
  always_comb begin
    nxt     = cur;
    nxt.cnt = f_next_cnt(cur.cnt, nbytes);
    nxt.ioa = f_next_ioa(cur.ioa, cur.ctl[CB_IOA_FIX], nbytes);
    nxt.bap = f_next_bap(cur.bap, cur.ctl[CB_BAP_FIX], cur.ctl[CB_BAP_DEC], nbytes);
    zero_left = (nxt.cnt == '0);
  end
endmodule

// File: rtl/dma_step_seq.sv
module dma_step_seq
  import dma_step_pkg::*;
#(
  parameter int CHAN_W = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CHAN_W-1:0] start_chan,
  input  logic              stop_req,
  input  desc_t             desc_in,
  input  logic [BAP_W-1:0]  src_a,
  input  logic [BAP_W-1:0]  src_b,
  input  logic [BAP_W-1:0]  dst_a,
  input  logic [BAP_W-1:0]  dst_b,
  input  logic              rd_word,
  input  logic              rd_split,
  input  logic              wr_word,
  input  logic              wr_split,
  input  logic              src_is_io,
  input  logic              dst_is_io,
  input  desc_t             upd_desc,
  input  logic              upd_zero,
  output desc_t             desc_q,
  output logic              busy,
  output logic              done,
  output logic [CHAN_W-1:0] done_chan,
  output logic              blk_end,
  output logic              blk_stop,
  output desc_t             desc_wb,
  output logic              mem_req,
  output logic              mem_we,
  output logic [BAP_W-1:0]  mem_addr,
  output logic [1:0]        mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready
);
  step_st_t          st, st_nx;
  logic [DATA_W-1:0] hold;
  logic [CHAN_W-1:0] chan_q;

  // named internal events
  logic hs, step_fin, abort_now, go, acc_is_io;

  assign hs        = mem_req && mem_ready;
  assign abort_now = start && (st == ST_IDLE) && desc_in.ctl[CB_STOP] && stop_req;
  assign go        = start && (st == ST_IDLE) && !abort_now;
  assign step_fin  = hs && ((st == ST_WR_A && !wr_split) || st == ST_WR_B);
  assign busy      = (st != ST_IDLE);

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (go) st_nx = ST_RD_A;
      ST_RD_A: if (hs) st_nx = rd_split ? ST_RD_B : ST_WR_A;
      ST_RD_B: if (hs) st_nx = ST_WR_A;
      ST_WR_A: if (hs) st_nx = wr_split ? ST_WR_B : ST_IDLE;
      ST_WR_B: if (hs) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    mem_req   = (st != ST_IDLE);
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_be    = 2'b00;
    mem_wdata = '0;
    acc_is_io = 1'b0;
    unique case (st)
      ST_RD_A: begin
        mem_addr  = src_a;
        mem_be    = rd_word ? 2'b11 : f_lane(src_a[0]);
        acc_is_io = src_is_io;
      end
      ST_RD_B: begin
        mem_addr  = src_b;
        mem_be    = f_lane(src_b[0]);
        acc_is_io = src_is_io;
      end
      ST_WR_A: begin
        mem_we    = 1'b1;
        mem_addr  = dst_a;
        mem_be    = wr_word ? 2'b11 : f_lane(dst_a[0]);
        mem_wdata = wr_word ? hold : {2{hold[BYTE_W-1:0]}};
        acc_is_io = dst_is_io;
      end
      ST_WR_B: begin
        mem_we    = 1'b1;
        mem_addr  = dst_b;
        mem_be    = f_lane(dst_b[0]);
        mem_wdata = {2{hold[DATA_W-1:BYTE_W]}};
        acc_is_io = dst_is_io;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      desc_q    <= '0;
      chan_q    <= '0;
      hold      <= '0;
      done      <= 1'b0;
      blk_end   <= 1'b0;
      blk_stop  <= 1'b0;
      done_chan <= '0;
      desc_wb   <= '0;
    end else begin
      st <= st_nx;
      if (go) begin
        desc_q <= desc_in;
        chan_q <= start_chan;
      end
      if (hs && st == ST_RD_A) begin
        if (rd_word) hold <= mem_rdata;
        else         hold[BYTE_W-1:0] <= f_pick_byte(mem_rdata, src_a[0]);
      end
      if (hs && st == ST_RD_B)
        hold[DATA_W-1:BYTE_W] <= f_pick_byte(mem_rdata, src_b[0]);
      done     <= step_fin || abort_now;
      blk_end  <= (step_fin && upd_zero) || abort_now;
      blk_stop <= abort_now;
      if (step_fin) begin
        desc_wb   <= upd_desc;
        done_chan <= chan_q;
      end else if (abort_now) begin
        desc_wb   <= desc_in;
        done_chan <= start_chan;
      end
    end
  end

  // R11: a pending access is held while ready is low
  assert_hold_on_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_we));

  // R2: two-lane accesses are always word aligned
  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_be == 2'b11 |-> !mem_addr[0]);

  // R6: I/O-side accesses stay in the low 64 KB page
  assert_io_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && acc_is_io |-> mem_addr[BAP_W-1:IOA_W] == '0);

  // R8: an abort reports end and completion together
  assert_stop_has_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_stop |-> blk_end && done);

  // R9: end of a normal step iff the returned counter is empty
  assert_end_matches_cnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !blk_stop |-> blk_end == (desc_wb.cnt == '0));

  // R10: completion only with busy low, and busy falls only at completion
  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_busy_fall_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

// File: rtl/dma_step_engine.sv
module dma_step_engine
  import dma_step_pkg::*;
#(
  parameter int CHAN_W = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CHAN_W-1:0] start_chan,
  input  logic              stop_req,
  input  logic [63:0]       desc_in,
  output logic              busy,
  output logic              done,
  output logic [CHAN_W-1:0] done_chan,
  output logic              blk_end,
  output logic              blk_stop,
  output logic [63:0]       desc_wb,
  output logic              mem_req,
  output logic              mem_we,
  output logic [23:0]       mem_addr,
  output logic [1:0]        mem_be,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_ready
);
  desc_t            desc_in_s, desc_q, upd_desc, desc_wb_s;
  logic [BAP_W-1:0] src_a, src_b, dst_a, dst_b;
  nbytes_t          nbytes;
  logic             rd_word, rd_split, wr_word, wr_split, src_is_io, dst_is_io, upd_zero;

  assign desc_in_s = desc_t'(desc_in);
  assign desc_wb   = DESC_W'(desc_wb_s);

  dma_step_route u_route (
    .desc(desc_q), .src_a(src_a), .src_b(src_b), .dst_a(dst_a), .dst_b(dst_b),
    .nbytes(nbytes), .rd_word(rd_word), .rd_split(rd_split), .wr_word(wr_word),
    .wr_split(wr_split), .src_is_io(src_is_io), .dst_is_io(dst_is_io)
  );

  dma_step_update u_update (
    .cur(desc_q), .nbytes(nbytes), .nxt(upd_desc), .zero_left(upd_zero)
  );

  dma_step_seq #(.CHAN_W(CHAN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_chan(start_chan), .stop_req(stop_req),
    .desc_in(desc_in_s), .src_a(src_a), .src_b(src_b), .dst_a(dst_a), .dst_b(dst_b),
    .rd_word(rd_word), .rd_split(rd_split), .wr_word(wr_word), .wr_split(wr_split),
    .src_is_io(src_is_io), .dst_is_io(dst_is_io), .upd_desc(upd_desc), .upd_zero(upd_zero),
    .desc_q(desc_q), .busy(busy), .done(done), .done_chan(done_chan), .blk_end(blk_end),
    .blk_stop(blk_stop), .desc_wb(desc_wb_s), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );
endmodule

// File: tb/dma_step_engine_tb.sv
module dma_step_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  start_chan = '0;
  logic        stop_req = 1'b0;
  logic [63:0] desc_in = '0;
  logic        busy, done, blk_end, blk_stop, mem_req, mem_we, mem_ready;
  logic [3:0]  done_chan;
  logic [63:0] desc_wb;
  logic [23:0] mem_addr;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata, mem_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  logic       stall_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  typedef struct { logic [23:0] addr; logic we; logic [1:0] be; logic [15:0] wdata; string tag; } acc_t;
  typedef struct { logic [63:0] desc; logic endf; logic stopf; logic [3:0] chan; string tag; } res_t;
  acc_t exp_acc[$];
  res_t exp_res[$];

  always #5 clk = ~clk;

  dma_step_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_chan(start_chan), .stop_req(stop_req),
    .desc_in(desc_in), .busy(busy), .done(done), .done_chan(done_chan), .blk_end(blk_end),
    .blk_stop(blk_stop), .desc_wb(desc_wb), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  function automatic logic [7:0] mbyte(input logic [23:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [1:0] lane_of(input logic [23:0] a);
    return (a[0] == 1'b0) ? 2'b01 : 2'b10;
  endfunction

  assign mem_rdata = {mbyte({mem_addr[23:1], 1'b1}), mbyte({mem_addr[23:1], 1'b0})};

  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready = stall_en ? lfsr[0] : 1'b1;
  end

  task automatic push_acc(input logic [23:0] a, input logic we, input logic [1:0] be,
                          input logic [15:0] wd, input string tag);
    acc_t it;
    it.addr = a; it.we = we; it.be = be; it.wdata = wd; it.tag = tag;
    exp_acc.push_back(it);
  endtask

  // expected model, built from the requirement text
  task automatic predict(input logic [63:0] d, input logic [3:0] ch, input logic stp, input string tag);
    res_t r;
    logic [7:0]  ctl;
    logic [23:0] bp, s0, s1, d0, d1, io0, io1;
    logic [15:0] io, cn;
    logic [7:0]  b0, b1;
    int nb;
    ctl = d[31:24]; bp = d[23:0]; io = d[47:32]; cn = d[63:48];
    r.chan = ch; r.tag = tag;
    if (ctl[0] && stp) begin
      r.desc = d; r.endf = 1'b1; r.stopf = 1'b1;
      exp_res.push_back(r);
      return;
    end
    nb = (ctl[3] && cn != 16'd1) ? 2 : 1;
    io0 = {8'h00, io}; io1 = {8'h00, io + 16'd1};
    if (ctl[1]) begin s0 = bp; s1 = bp + 24'd1; d0 = io0; d1 = io1; end
    else        begin s0 = io0; s1 = io1; d0 = bp; d1 = bp + 24'd1; end
    b0 = mbyte(s0); b1 = mbyte(s1);
    if (nb == 1) push_acc(s0, 1'b0, lane_of(s0), 16'h0, tag);
    else if (!s0[0]) push_acc(s0, 1'b0, 2'b11, 16'h0, tag);
    else begin push_acc(s0, 1'b0, lane_of(s0), 16'h0, tag); push_acc(s1, 1'b0, lane_of(s1), 16'h0, tag); end
    if (nb == 1) push_acc(d0, 1'b1, lane_of(d0), {b0, b0}, tag);
    else if (!d0[0]) push_acc(d0, 1'b1, 2'b11, {b1, b0}, tag);
    else begin push_acc(d0, 1'b1, lane_of(d0), {b0, b0}, tag); push_acc(d1, 1'b1, lane_of(d1), {b1, b1}, tag); end
    cn = cn - 16'(nb);
    if (!ctl[4]) io = io + 16'(nb);
    if (!ctl[2]) bp = ctl[5] ? bp - 24'(nb) : bp + 24'(nb);
    r.desc = {cn, io, ctl, bp}; r.endf = (cn == 16'd0); r.stopf = 1'b0;
    exp_res.push_back(r);
  endtask

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    #1;
    if (rst_n && mem_req && mem_ready) begin
      n_cmp++;
      if (exp_acc.size() == 0) begin
        n_bad++;
        $display("FAIL R10 unexpected access: actual addr=%h we=%b expected none", mem_addr, mem_we);
      end else begin
        acc_t e;
        e = exp_acc.pop_front();
        if (mem_addr !== e.addr || mem_we !== e.we || mem_be !== e.be ||
            (e.we && (((mem_wdata ^ e.wdata) & {{8{e.be[1]}}, {8{e.be[0]}}}) != 16'h0))) begin
          n_bad++;
          $display("FAIL %s access: actual addr=%h we=%b be=%b wd=%h expected addr=%h we=%b be=%b wd=%h",
                   e.tag, mem_addr, mem_we, mem_be, mem_wdata, e.addr, e.we, e.be, e.wdata);
        end
      end
    end
    if (rst_n && done) begin
      n_cmp++;
      if (exp_res.size() == 0) begin
        n_bad++;
        $display("FAIL R10 unexpected completion: actual desc=%h expected none", desc_wb);
      end else begin
        res_t e;
        e = exp_res.pop_front();
        if (desc_wb !== e.desc || blk_end !== e.endf || blk_stop !== e.stopf ||
            done_chan !== e.chan || busy !== 1'b0 || exp_acc.size() != 0) begin
          n_bad++;
          $display("FAIL %s result: actual desc=%h end=%b stop=%b ch=%0d busy=%b left=%0d expected desc=%h end=%b stop=%b ch=%0d busy=0 left=0",
                   e.tag, desc_wb, blk_end, blk_stop, done_chan, busy, exp_acc.size(),
                   e.desc, e.endf, e.stopf, e.chan);
        end
      end
    end
  end

  task automatic run_step(input logic [63:0] d, input logic [3:0] ch, input logic stp,
                          input string tag, output logic [63:0] wb);
    predict(d, ch, stp, tag);
    @(negedge clk);
    start = 1'b1; start_chan = ch; desc_in = d; stop_req = stp;
    @(negedge clk);
    start = 1'b0; stop_req = 1'b0;
    if (!(d[24] && stp)) begin
      n_cmp++;
      if (busy !== 1'b1) begin
        n_bad++;
        $display("FAIL R10 busy after start: actual %b expected 1", busy);
      end
    end
    while (!done) @(negedge clk);
    wb = desc_wb;
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R10 watchdog: actual hung expected completion");
    finish_run();
  end

  // descriptor fields: {cnt, ioa, ctl, bap}
  initial begin
    logic [63:0] wb;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (busy !== 1'b0 || mem_req !== 1'b0 || done !== 1'b0) begin
      n_bad++;
      $display("FAIL R12 in reset: actual busy=%b req=%b done=%b expected 0 0 0", busy, mem_req, done);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_cmp++;
    if (busy !== 1'b0 || mem_req !== 1'b0 || done !== 1'b0) begin
      n_bad++;
      $display("FAIL R12 after reset: actual busy=%b req=%b done=%b expected 0 0 0", busy, mem_req, done);
    end
    // R1 R7 R13: byte, I/O to buffer, io fixed, buffer up
    run_step({16'd8, 16'h0123, 8'h10, 24'h40_2000}, 4'd0, 1'b0, "R1", wb);
    // R7: byte, buffer to I/O, odd buffer, both incrementing
    run_step({16'd5, 16'h0200, 8'h02, 24'h12_3457}, 4'd3, 1'b0, "R7", wb);
    // R2: word, both even
    run_step({16'd10, 16'h0400, 8'h08, 24'h00_8000}, 4'd1, 1'b0, "R2", wb);
    // R3: word, odd I/O side read, even buffer write
    run_step({16'd10, 16'h0401, 8'h08, 24'h00_8000}, 4'd2, 1'b0, "R3", wb);
    // R3: word, odd buffer read, even I/O write
    run_step({16'd6, 16'h0500, 8'h0A, 24'h01_0003}, 4'd4, 1'b0, "R3", wb);
    // R3: word, both odd
    run_step({16'd6, 16'h0601, 8'h08, 24'h02_0011}, 4'd5, 1'b0, "R3", wb);
    // R4 R9: word with one byte left
    run_step({16'd1, 16'h0700, 8'h08, 24'h03_0000}, 4'd6, 1'b0, "R4", wb);
    // R5: counter zero, byte and word
    run_step({16'd0, 16'h0800, 8'h00, 24'h04_0000}, 4'd7, 1'b0, "R5", wb);
    run_step({16'd0, 16'h0800, 8'h08, 24'h04_0000}, 4'd7, 1'b0, "R5", wb);
    // R6: buffer decrement word, io wrap byte and odd word wrap
    run_step({16'd4, 16'h0900, 8'h28, 24'h00_0000}, 4'd8, 1'b0, "R6", wb);
    run_step({16'd3, 16'hFFFF, 8'h04, 24'h05_0000}, 4'd9, 1'b0, "R6", wb);
    run_step({16'd3, 16'hFFFF, 8'h0A, 24'h05_1000}, 4'd9, 1'b0, "R6", wb);
    // R8: stop enabled aborts, stop disabled ignored
    run_step({16'd7, 16'h0A00, 8'h01, 24'h06_0000}, 4'd10, 1'b1, "R8", wb);
    run_step({16'd7, 16'h0A00, 8'h00, 24'h06_0000}, 4'd11, 1'b1, "R8", wb);
    // R11: stalls on every access type
    stall_en = 1'b1;
    run_step({16'd9, 16'h0B01, 8'h08, 24'h07_0005}, 4'd12, 1'b0, "R11", wb);
    run_step({16'd9, 16'h0B00, 8'h0A, 24'h07_0100}, 4'd12, 1'b0, "R11", wb);
    run_step({16'd9, 16'h0B00, 8'h02, 24'h07_0101}, 4'd12, 1'b0, "R11", wb);
    // R9: a block run down to its end by feeding results back
    wb = {16'd5, 16'h0C00, 8'h08, 24'h08_0000};
    for (int i = 0; i < 3; i++) run_step(wb, 4'd13, 1'b0, "R9", wb);
    stall_en = 1'b0;
    // R10: start while busy is ignored
    predict({16'd6, 16'h0D01, 8'h08, 24'h09_0000}, 4'd14, 1'b0, "R10");
    @(negedge clk);
    start = 1'b1; start_chan = 4'd14; desc_in = {16'd6, 16'h0D01, 8'h08, 24'h09_0000};
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; start_chan = 4'd15; desc_in = {16'd2, 16'h0E00, 8'h00, 24'h0A_0000};
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
    n_cmp++;
    if (exp_res.size() != 0 || exp_acc.size() != 0 || mem_req !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 leftover: actual res=%0d acc=%0d req=%b expected 0 0 0",
               exp_res.size(), exp_acc.size(), mem_req);
    end
    finish_run();
  end
endmodule